// File: doc/BRIEF.md
# VBI ancillary packet formatter

This block turns one sliced vertical-blanking-interval line into a single ancillary data packet. It sends the packet one byte per clock onto an 8-bit video output during horizontal blanking. A start pulse arrives right after the end-of-active-video code. With that pulse come the line's attributes: field, whether the line lies in vertical blanking, the 6-bit service format code, the 10-bit line number, two match flags, a single-error flag and the payload length. The block then sends a fixed eight-byte header. The slicer's payload bytes follow, fetched through a valid/ready byte interface. An 8-bit checksum and zero fill bytes close the packet.

Three of the header bytes carry 6-bit identifiers protected by a parity bit and its complement. This lets a receiver tell them apart from the video sync codes. Between packets the output rests at the blanking level. A busy flag covers the whole transmission.

Top module: `vbi_anc_packer`

## Requirements
- R1: On the clock edge that samples `eav_start` while the block is idle, the output shows byte 0 = 00h with `anc_valid` high. Bytes 1 and 2 follow on the next two cycles, both FFh.
- R2: Header bytes 3, 4 and 5 each put a 6-bit value in bits 5:0. Bit 6 is the even-parity bit over bits 5:0, so that bits 6:0 hold an even number of ones. Bit 7 is the inverse of bit 6.
- R3: The 6-bit value of byte 3 is 11h for field 1 (`field_id`=0) inside vertical blanking and 13h for field 1 outside it. It is 15h for field 2 inside vertical blanking and 17h for field 2 outside it. The resulting bytes are 91h, 53h, 55h and 97h.
- R4: The 6-bit value of byte 4 is `fmt_code` as captured at the start pulse.
- R5: The 6-bit value of byte 5 is the number of 4-byte words from byte 8 through the last fill byte. This equals floor(len/4)+1 for a payload of len bytes.
- R6: Byte 6 is line number bits 7:0. Byte 7 holds line bits 9:8 in bits 1:0, the second match flag in bit 2, the first match flag in bit 3, the error flag in bit 4, and zero in bits 7:5.
- R7: Payload bytes appear from byte 8 on, in the order accepted. `pay_ready` is high only in the payload phase. A cycle with `pay_ready` high and `pay_valid` low produces no output byte.
- R8: After the last payload byte comes one byte equal to the sum of all payload bytes modulo 256. A zero-length payload gives checksum 00h right after byte 7.
- R9: Zero bytes follow the checksum until the packet length from byte 0 is a multiple of four. The fill count is 0 to 3.
- R10: A start pulse that arrives while `busy` is high is ignored. The packet in flight keeps its values and no extra bytes are sent.
- R11: After reset and between packets, `anc_byte` is 10h, `anc_valid` is low and `busy` is low. `busy` is high from the first packet byte through the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eav_start | input | 1 | Pulse after the end-of-active-video code; starts a packet |
| field_id | input | 1 | 0 = first field, 1 = second field |
| in_vblank | input | 1 | Line lies inside vertical blanking |
| fmt_code | input | 6 | Service format code of the line |
| line_num | input | 10 | Video line number |
| match1 | input | 1 | First match flag |
| match2 | input | 1 | Second match flag |
| edc_err | input | 1 | Single error detected by error correction |
| pay_len | input | LEN_W (7) | Payload length in bytes, 0 to MAX_PAYLOAD |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Block takes the offered byte this cycle |
| anc_byte | output | 8 | Output byte stream, 10h when idle |
| anc_valid | output | 1 | `anc_byte` holds a packet byte |
| busy | output | 1 | Packet transmission in progress |

## Verification
Packets are sent for all four field/blanking combinations, so that a swapped DID bit shows as a wrong byte 3. Payload lengths of 0, 2, 3, 5, 7, 43 and 64 cover every fill count from 0 to 3 and word counts from 1 to 17. The 64-byte payload uses large byte values so that the checksum wraps. One packet uses a 10-bit line number with both high bits set, and a second sets the flags one at a time, which catches swapped bit positions in byte 7. A payload source with idle gaps checks that stalls produce no bytes. A start pulse with different field data injected mid-packet must leave the byte stream unchanged.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_PAY  = 3'd2,
        ST_SUM  = 3'd3,
        ST_FILL = 3'd4
    } anc_state_e;

    // level driven on the byte output between packets
    localparam logic [7:0] BLANK_BYTE = 8'h10;

    // fixed upper three bits of the 6-bit data identifier value
    localparam logic [2:0] DID_TAG = 3'b010;

endpackage

// File: rtl/anc_id_word.sv
// Protects a 6-bit identifier with even parity and its complement.
module anc_id_word (
    input  logic [5:0] value,
    output logic [7:0] word
);
    logic par;

    always_comb begin
        par  = ^value;
        word = {~par, par, value};
    end
endmodule

// File: rtl/anc_len_calc.sv
// Word count and fill count for a payload of len bytes plus one checksum byte.
module anc_len_calc #(
    parameter int LW = 7
) (
    input  logic [LW-1:0] len,
    output logic [5:0]    words,
    output logic [1:0]    fill
);
    always_comb begin
        // ceil((len+1)/4) == floor(len/4) + 1
        words = 6'(len[LW-1:2]) + 6'd1;
        // (4 - (len+1) mod 4) mod 4 == (-(len+1)) mod 4 == ~len mod 4
        fill  = ~len[1:0];
    end
endmodule

// File: rtl/vbi_anc_packer.sv
module vbi_anc_packer
    import vbi_anc_pkg::*;
#(
    parameter int MAX_PAYLOAD = 64,
    localparam int LEN_W = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eav_start,
    input  logic             field_id,
    input  logic             in_vblank,
    input  logic [5:0]       fmt_code,
    input  logic [9:0]       line_num,
    input  logic             match1,
    input  logic             match2,
    input  logic             edc_err,
    input  logic [LEN_W-1:0] pay_len,
    input  logic [7:0]       pay_data,
    input  logic             pay_valid,
    output logic             pay_ready,
    output logic [7:0]       anc_byte,
    output logic             anc_valid,
    output logic             busy
);
    localparam int N_ID = 3;

    typedef struct packed {
        anc_state_e       st;
        logic [2:0]       hidx;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [1:0]       fill;
        logic [5:0]       words;
        logic [7:0]       sum;
        logic             fld;
        logic             vb;
        logic [5:0]       fmt;
        logic [9:0]       line;
        logic             m1;
        logic             m2;
        logic             err;
        logic [7:0]       obyte;
        logic             oval;
    } regs_t;

    regs_t q, d;

    logic [5:0] calc_words;
    logic [1:0] calc_fill;
    logic [5:0] id_val  [N_ID];
    logic [7:0] id_word [N_ID];

    anc_len_calc #(.LW(LEN_W)) u_len (
        .len   (pay_len),
        .words (calc_words),
        .fill  (calc_fill)
    );

    assign id_val[0] = {DID_TAG, q.fld, ~q.vb, 1'b1};
    assign id_val[1] = q.fmt;
    assign id_val[2] = q.words;

    for (genvar g = 0; g < N_ID; g++) begin : g_id
        anc_id_word u_id (
            .value (id_val[g]),
            .word  (id_word[g])
        );
    end

    assign busy      = (q.st != ST_IDLE) || q.oval;
    assign pay_ready = (q.st == ST_PAY);
    assign anc_byte  = q.obyte;
    assign anc_valid = q.oval;

    always_comb begin
        d       = q;
        d.obyte = BLANK_BYTE;
        d.oval  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (eav_start && !busy) begin
                    d.fld   = field_id;
                    d.vb    = in_vblank;
                    d.fmt   = fmt_code;
                    d.line  = line_num;
                    d.m1    = match1;
                    d.m2    = match2;
                    d.err   = edc_err;
                    d.len   = pay_len;
                    d.words = calc_words;
                    d.fill  = calc_fill;
                    d.sum   = 8'h00;
                    d.cnt   = '0;
                    d.hidx  = 3'd1;
                    d.obyte = 8'h00;
                    d.oval  = 1'b1;
                    d.st    = ST_HDR;
                end
            end
            ST_HDR: begin
                d.oval = 1'b1;
                case (q.hidx)
                    3'd1, 3'd2: d.obyte = 8'hFF;
                    3'd3:       d.obyte = id_word[0];
                    3'd4:       d.obyte = id_word[1];
                    3'd5:       d.obyte = id_word[2];
                    3'd6:       d.obyte = q.line[7:0];
                    default:    d.obyte = {3'b000, q.err, q.m1, q.m2, q.line[9:8]};
                endcase
                d.hidx = q.hidx + 3'd1;
                if (q.hidx == 3'd7) begin
                    d.st = (q.len == '0) ? ST_SUM : ST_PAY;
                end
            end
            ST_PAY: begin
                if (pay_valid) begin
                    d.obyte = pay_data;
                    d.oval  = 1'b1;
                    d.sum   = q.sum + pay_data;
                    d.cnt   = q.cnt + LEN_W'(1);
                    if (q.cnt == q.len - LEN_W'(1)) begin
                        d.st = ST_SUM;
                    end
                end
            end
            ST_SUM: begin
                d.obyte = q.sum;
                d.oval  = 1'b1;
                d.cnt   = LEN_W'(q.fill);
                d.st    = (q.fill == 2'd0) ? ST_IDLE : ST_FILL;
            end
            ST_FILL: begin
                d.obyte = 8'h00;
                d.oval  = 1'b1;
                d.cnt   = q.cnt - LEN_W'(1);
                if (q.cnt == LEN_W'(1)) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.obyte <= BLANK_BYTE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/vbi_anc_packer_sva.sv
module vbi_anc_packer_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       anc_valid,
    input logic [7:0] anc_byte,
    input logic       pay_ready,
    input logic       pay_valid
);
    // byte position inside the current packet, counted independently
    logic [15:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pos_q <= '0;
        else if (!busy)     pos_q <= '0;
        else if (anc_valid) pos_q <= pos_q + 16'd1;
    end

    assert_preamble_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> anc_valid && anc_byte == 8'h00);

    assert_preamble_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy && anc_valid && (pos_q == 16'd1 || pos_q == 16'd2) |-> anc_byte == 8'hFF);

    assert_id_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && anc_valid && pos_q >= 16'd3 && pos_q <= 16'd5
        |-> anc_byte[6] == ^anc_byte[5:0] && anc_byte[7] == ~anc_byte[6]);

    assert_did_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && anc_valid && pos_q == 16'd3
        |-> anc_byte == 8'h91 || anc_byte == 8'h53 || anc_byte == 8'h55 || anc_byte == 8'h97);

    assert_flags_top_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && anc_valid && pos_q == 16'd7 |-> anc_byte[7:5] == 3'b000);

    assert_ready_in_packet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> busy);

    assert_stall_no_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready && !pay_valid |=> !anc_valid);

    assert_length_mult4_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> pos_q[1:0] == 2'b00 && pos_q >= 16'd12);

    assert_idle_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !anc_valid && anc_byte == 8'h10 && !pay_ready);
endmodule

bind vbi_anc_packer vbi_anc_packer_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .anc_valid (anc_valid),
    .anc_byte  (anc_byte),
    .pay_ready (pay_ready),
    .pay_valid (pay_valid)
);

// File: tb/sim_vbi_anc_packer.sv
module sim_vbi_anc_packer;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP = 64;
    localparam int PLW  = $clog2(MAXP + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           eav_start = 1'b0;
    logic           field_id = 1'b0;
    logic           in_vblank = 1'b0;
    logic [5:0]     fmt_code = '0;
    logic [9:0]     line_num = '0;
    logic           match1 = 1'b0;
    logic           match2 = 1'b0;
    logic           edc_err = 1'b0;
    logic [PLW-1:0] pay_len = '0;
    logic [7:0]     pay_data = '0;
    logic           pay_valid = 1'b0;
    logic           pay_ready;
    logic [7:0]     anc_byte;
    logic           anc_valid;
    logic           busy;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [7:0] b;
        string      tag;
    } exp_t;

    exp_t expq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    vbi_anc_packer #(.MAX_PAYLOAD(MAXP)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .eav_start (eav_start),
        .field_id  (field_id),
        .in_vblank (in_vblank),
        .fmt_code  (fmt_code),
        .line_num  (line_num),
        .match1    (match1),
        .match2    (match2),
        .edc_err   (edc_err),
        .pay_len   (pay_len),
        .pay_data  (pay_data),
        .pay_valid (pay_valid),
        .pay_ready (pay_ready),
        .anc_byte  (anc_byte),
        .anc_valid (anc_valid),
        .busy      (busy)
    );

    function automatic logic [7:0] prot(input logic [5:0] v);
        logic p;
        p = ^v;
        return {~p, p, v};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b, input string tag);
        exp_t e;
        e.b   = b;
        e.tag = tag;
        expq.push_back(e);
    endtask

    // monitor: pop and compare every byte the design emits
    always @(negedge clk) begin
        if (rst_n && anc_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R10 unexpected byte", {24'h0, anc_byte}, 32'h0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(anc_byte == e.b, e.tag, {24'h0, anc_byte}, {24'h0, e.b});
                check(busy, "R11 busy while sending", {31'h0, busy}, 32'h1);
            end
        end
    end

    task automatic check_idle(input string tag);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!busy && !anc_valid && anc_byte == 8'h10, tag,
                  {22'h0, busy, anc_valid, anc_byte}, 32'h10);
        end
        check(expq.size() == 0, "R10 all expected bytes emitted", expq.size(), 32'h0);
    endtask

    function automatic logic [7:0] pay_byte(input int seed, input int i);
        return 8'(seed + i * 61 + (i >> 1));
    endfunction

    // driver: builds the expected packet, then drives start and payload
    task automatic send_pkt(input logic fld, input logic vb, input logic [5:0] fmt,
                            input logic [9:0] line, input logic m1, input logic m2,
                            input logic er, input int len, input int seed,
                            input bit gaps, input bit poke);
        logic [7:0] sum;
        int         nn;
        int         fill;
        sum  = 8'h00;
        nn   = len / 4 + 1;
        fill = 4 * nn - len - 1;
        push(8'h00, "R1 byte0");
        push(8'hFF, "R1 byte1");
        push(8'hFF, "R1 byte2");
        push(prot({3'b010, fld, ~vb, 1'b1}), "R2,R3 DID");
        push(prot(fmt), "R2,R4 SDID");
        push(prot(6'(nn)), "R2,R5 word count");
        push(line[7:0], "R6 line low");
        push({3'b000, er, m1, m2, line[9:8]}, "R6 flags");
        for (int i = 0; i < len; i++) begin
            push(pay_byte(seed, i), "R7 payload");
            sum = sum + pay_byte(seed, i);
        end
        push(sum, "R8 checksum");
        for (int i = 0; i < fill; i++) push(8'h00, "R9 fill");

        @(negedge clk);
        field_id  = fld;
        in_vblank = vb;
        fmt_code  = fmt;
        line_num  = line;
        match1    = m1;
        match2    = m2;
        edc_err   = er;
        pay_len   = PLW'(len);
        eav_start = 1'b1;
        @(negedge clk);
        eav_start = 1'b0;
        check(anc_valid && anc_byte == 8'h00, "R1 first byte on start edge",
              {23'h0, anc_valid, anc_byte}, 32'h100);
        if (poke) begin
            // R10: second start while busy, with different line data
            field_id  = ~fld;
            in_vblank = ~vb;
            fmt_code  = ~fmt;
            line_num  = ~line;
            pay_len   = PLW'(1);
            eav_start = 1'b1;
            @(negedge clk);
            eav_start = 1'b0;
        end
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 1)) begin
                pay_valid = 1'b0;
                @(negedge clk);
                @(negedge clk);
            end
            pay_valid = 1'b1;
            pay_data  = pay_byte(seed, i);
            while (!pay_ready) @(negedge clk);
            @(negedge clk);
        end
        pay_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "R11 watchdog expired", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !anc_valid && anc_byte == 8'h10 && !pay_ready, "R11 reset state",
              {21'h0, pay_ready, busy, anc_valid, anc_byte}, 32'h10);
        rst_n = 1'b1;
        check_idle("R11 idle after reset");

        // field 1, blanking, closed-caption style, 2 bytes
        send_pkt(1'b0, 1'b1, 6'h01, 10'd21, 1'b0, 1'b0, 1'b0, 2, 8'h41, 1'b0, 1'b0);
        check_idle("R11 idle after packet");
        // field 2, blanking, only match1
        send_pkt(1'b1, 1'b1, 6'h09, 10'd21, 1'b1, 1'b0, 1'b0, 2, 8'h13, 1'b0, 1'b0);
        check_idle("R11 idle after packet");
        // field 1, outside blanking, high line bits, match2 and error, gappy source
        send_pkt(1'b0, 1'b0, 6'h00, 10'h3A5, 1'b0, 1'b1, 1'b1, 43, 8'h07, 1'b1, 1'b0);
        check_idle("R11 idle after packet");
        // field 2, outside blanking, empty payload
        send_pkt(1'b1, 1'b0, 6'h2A, 10'h100, 1'b0, 1'b0, 1'b1, 0, 8'h00, 1'b0, 1'b0);
        check_idle("R11 idle after packet");
        // fill count 0 and 2 and 0 with two words
        send_pkt(1'b0, 1'b1, 6'h03, 10'd14, 1'b1, 1'b1, 1'b0, 3, 8'hC9, 1'b0, 1'b0);
        check_idle("R11 idle after packet");
        send_pkt(1'b1, 1'b1, 6'h04, 10'd16, 1'b0, 1'b0, 1'b0, 5, 8'h88, 1'b1, 1'b0);
        check_idle("R11 idle after packet");
        send_pkt(1'b0, 1'b0, 6'h3F, 10'h2FF, 1'b1, 1'b0, 1'b1, 7, 8'hFE, 1'b0, 1'b0);
        check_idle("R11 idle after packet");
        // longest payload, large bytes so the checksum wraps
        send_pkt(1'b1, 1'b0, 6'h12, 10'h0FF, 1'b0, 1'b1, 1'b0, 64, 8'hF0, 1'b0, 1'b0);
        check_idle("R11 idle after packet");
        // start pulse injected mid-packet must be ignored
        send_pkt(1'b0, 1'b1, 6'h05, 10'd10, 1'b1, 1'b0, 1'b0, 9, 8'h5A, 1'b0, 1'b1);
        check_idle("R10 idle after ignored start");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule